// File: doc/BRIEF.md
# Dither Correction Cycle Sequencer

This block times the measurement loop of a cable-drop compensator. An external oscillator supplies a single-clock tick enable. The block divides that tick by a power of two to set the dither period. Within each period it steps through five phases, and it shows the current phase on a one-hot strobe bus.

The first half of the period belongs to voltage regulation. It ends with a window that samples the high output voltage and the output current together. The second half commands the reduced current setpoint, which is 90% of the sampled current. It ends with a low-voltage sample window, followed by a single-tick window that captures the voltage difference.

An enable can move the half boundary pseudo-randomly from cycle to cycle, which spreads any beat tones. An undervoltage-ok input gates the whole sequence and restarts it. An overvoltage input withholds the correction and starts a new soft-correct ramp. The oscillator tick is also passed out so that an external regulator can synchronise to it.

Top module: `dither_seq`

## Requirements
- R1: `sync_out` equals `osc_tick` in the same clock cycle.
- R2: With `div_sel` = d, one dither cycle lasts 2^(3+d) ticks. Code 0 gives 8 ticks and code 7 gives 1024 ticks.
- R3: While running, exactly one bit of `phase` is high. In reset, and from the clock after `uv_ok` is low, all bits of `phase` are low.
- R4: The `phase` encoding is: bit0 regulate voltage, bit1 track high voltage and current, bit2 regulate reduced current, bit3 track low voltage, bit4 track delta. Each cycle visits them in that order. With spread off and period P, the lengths in ticks are 3P/8, P/8, P/2-1-P/8, P/8 and 1.
- R5: With `spread_en` high, bit1 and bit3 still last P/8 ticks, bit4 lasts 1 tick, and the period stays P. The bit0 length varies from cycle to cycle within [P/4, P/2-1].
- R6: When `uv_ok` rises, a new cycle starts at once with bit0. `soft_pulse` is then high for exactly one tick period, starting at the first tick after the rise.
- R7: A rising `ov_flag` while running starts a new one-tick `soft_pulse`. `corr_en` is low during any clock in which `ov_flag` is high.
- R8: `corr_en` rises only at a cycle boundary. After a start or after an overvoltage event, it stays low until one full cycle has completed with `ov_flag` low at its end.
- R9: A change of `div_sel` within a cycle leaves that cycle's length unchanged. The new ratio applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-clock oscillator tick enable |
| div_sel | input | 3 | Division select, ratio 2^(3+div_sel) |
| spread_en | input | 1 | Pseudo-random boundary jitter enable |
| uv_ok | input | 1 | Supply above undervoltage threshold |
| ov_flag | input | 1 | Overvoltage present |
| sync_out | output | 1 | Tick forwarded for regulator synchronisation |
| phase | output | 5 | One-hot phase strobes (encoding in R4) |
| soft_pulse | output | 1 | Soft-correct restart, one tick period long |
| corr_en | output | 1 | Correction from the previous cycle may be applied |

## Verification
The bench builds the block with its default parameters: a base exponent of 3, a 3-bit select and a 16-bit jitter register. With these defaults, every phase length at the shortest ratio of 8 can be checked, where the track windows are a single tick. So can the longest ratio of 1024, and a 64-tick period where the jitter range is wide enough to show several distinct boundaries. A mid-cycle change of the select, and overvoltage and undervoltage events part-way through a cycle, expose the boundary-timed behaviour.

// File: rtl/dither_seq.sv
module dither_seq #(
  parameter int BASE_LOG = 3,
  parameter int DIV_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             spread_en,
  input  logic             uv_ok,
  input  logic             ov_flag,
  output logic             sync_out,
  output logic [4:0]       phase,
  output logic             soft_pulse,
  output logic             corr_en
);

  localparam int CW = BASE_LOG + (1 << DIV_W) - 1;
  localparam int LW = CW + 1;
  localparam logic [LW-1:0] ONE = LW'(1);

  logic [LW-1:0]    cnt, bnd;
  logic [DIV_W-1:0] dsel_q;
  logic [15:0]      lfsr;
  logic             uv_q, ov_q, have_d, arm;

  logic [LW-1:0] per_q, eighth_q, last_q;
  logic [LW-1:0] per_n, eighth_n, quarter_n, rnd, raw, lo, hi, bnd_n;
  logic          start, wrap, ov_rise;

  assign sync_out = osc_tick;

  assign per_q    = ONE << (BASE_LOG + int'(dsel_q));
  assign eighth_q = per_q >> 3;
  assign last_q   = per_q - ONE;

  assign per_n     = ONE << (BASE_LOG + int'(div_sel));
  assign eighth_n  = per_n >> 3;
  assign quarter_n = per_n >> 2;
  assign rnd       = LW'(lfsr) & (quarter_n - ONE);
  assign raw       = spread_en ? (per_n >> 1) + rnd - eighth_n : per_n >> 1;
  assign lo        = eighth_n + ONE;
  assign hi        = per_n - ONE - ONE - eighth_n;
  assign bnd_n     = (raw < lo) ? lo : (raw > hi) ? hi : raw;

  assign start   = uv_ok & ~uv_q;
  assign wrap    = uv_q & osc_tick & (cnt == last_q);
  assign ov_rise = uv_q & ov_flag & ~ov_q;

  always_comb begin
    phase = '0;
    if (uv_q) begin
      if (cnt == last_q)                 phase[4] = 1'b1;
      else if (cnt >= last_q - eighth_q) phase[3] = 1'b1;
      else if (cnt >= bnd)               phase[2] = 1'b1;
      else if (cnt >= bnd - eighth_q)    phase[1] = 1'b1;
      else                               phase[0] = 1'b1;
    end
  end

  assign corr_en = uv_q & ~ov_flag & have_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      bnd        <= '0;
      dsel_q     <= '0;
      lfsr       <= 16'hACE1;
      uv_q       <= 1'b0;
      ov_q       <= 1'b0;
      have_d     <= 1'b0;
      arm        <= 1'b0;
      soft_pulse <= 1'b0;
    end else begin
      uv_q <= uv_ok;
      ov_q <= ov_flag;
      if (!uv_ok) begin
        cnt        <= '0;
        have_d     <= 1'b0;
        arm        <= 1'b0;
        soft_pulse <= 1'b0;
      end else begin
        if (start || wrap) begin
          cnt    <= '0;
          dsel_q <= div_sel;
          bnd    <= bnd_n;
          lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end else if (uv_q && osc_tick) begin
          cnt <= cnt + ONE;
        end

        if (ov_rise)               have_d <= 1'b0;
        else if (wrap && !ov_flag) have_d <= 1'b1;

        if (start || ov_rise) arm <= 1'b1;
        else if (osc_tick)    arm <= 1'b0;

        if (osc_tick) soft_pulse <= arm;
      end
    end
  end

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q |-> $countones(phase) == 1);
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok |=> phase == '0);
  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q && uv_ok && phase[1] |=> phase[1] || phase[2]);
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q && uv_ok && phase[4] && osc_tick |=> phase[0]);
  a_r5_delta_hold: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q && uv_ok && phase[4] && !osc_tick |=> phase[4]);
  a_r6_soft_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_pulse) |-> $past(osc_tick));
  a_r8_corr_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(corr_en) |-> $past(phase[4] && osc_tick));

endmodule

// File: tb/sim_dither_seq.sv
module sim_dither_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       spread_en = 1'b0;
  logic       uv_ok = 1'b0;
  logic       ov_flag = 1'b0;
  logic       sync_out, soft_pulse, corr_en;
  logic [4:0] phase;

  int tests = 0;
  int fails = 0;
  int lens[5];
  int total, bad, distinct, first_rv;

  // div code, then expected lengths of bit0..bit4 with spread off
  localparam int VEC [5][6] = '{
    '{0,   3,   1,   2,   1, 1},
    '{1,   6,   2,   5,   2, 1},
    '{3,  24,   8,  23,   8, 1},
    '{4,  48,  16,  47,  16, 1},
    '{7, 384, 128, 383, 128, 1}
  };

  dither_seq u0 (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .div_sel(div_sel),
    .spread_en(spread_en), .uv_ok(uv_ok), .ov_flag(ov_flag), .sync_out(sync_out),
    .phase(phase), .soft_pulse(soft_pulse), .corr_en(corr_en));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    osc_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    osc_tick = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic start(input logic [2:0] d, input logic sp);
    uv_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    div_sel = d; spread_en = sp; uv_ok = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  // runs until the next cycle start; fills lens, total, bad
  task automatic measure();
    int prev;
    bit seen4;
    for (int k = 0; k < 5; k++) lens[k] = 0;
    total = 0; bad = 0; seen4 = 0; prev = 0;
    for (int k = 0; k < 5; k++) if (phase[k]) prev = k;
    for (int it = 0; it < 3000; it++) begin
      int b;
      b = 0;
      if ($countones(phase) != 1) bad++;
      for (int k = 0; k < 5; k++) if (phase[k]) b = k;
      if (seen4 && b == 0) break;
      if (b < prev) bad++;
      if (b == 4) seen4 = 1;
      prev = b;
      lens[b]++;
      total++;
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phase == 5'b0 && soft_pulse == 1'b0 && corr_en == 1'b0, "R3 reset state", phase, 0);
    rst_n = 1'b1;
    @(negedge clk);

    osc_tick = 1'b1; #1;
    check(sync_out == 1'b1, "R1 sync high", sync_out, 1);
    @(negedge clk); osc_tick = 1'b0; #1;
    check(sync_out == 1'b0, "R1 sync low", sync_out, 0);

    for (int v = 0; v < 5; v++) begin
      start(3'(VEC[v][0]), 1'b0);
      check(phase == 5'b00001, "R6 start in bit0", phase, 1);
      check(corr_en == 1'b0, "R8 no correction in first cycle", corr_en, 0);
      measure();
      check(bad == 0, "R3 one-hot and R4 order", bad, 0);
      check(total == (8 << VEC[v][0]), "R2 period", total, 8 << VEC[v][0]);
      for (int k = 0; k < 5; k++)
        check(lens[k] == VEC[v][k+1], "R4 phase length", lens[k], VEC[v][k+1]);
      check(corr_en == 1'b1, "R8 correction after first cycle", corr_en, 1);
    end

    start(3'd3, 1'b1);
    distinct = 0; first_rv = -1;
    for (int c = 0; c < 8; c++) begin
      measure();
      check(bad == 0 && total == 64, "R5 spread period", total, 64);
      check(lens[1] == 8 && lens[3] == 8 && lens[4] == 1, "R5 track windows", lens[1], 8);
      check(lens[0] >= 16 && lens[0] <= 31, "R5 jitter range", lens[0], 24);
      if (first_rv < 0) first_rv = lens[0];
      else if (lens[0] != first_rv) distinct++;
    end
    check(distinct > 0, "R5 boundary varies", distinct, 1);

    start(3'd0, 1'b0);
    check(soft_pulse == 1'b0, "R6 soft before tick", soft_pulse, 0);
    tick();
    check(soft_pulse == 1'b1, "R6 soft during first tick", soft_pulse, 1);
    tick();
    check(soft_pulse == 1'b0, "R6 soft one tick only", soft_pulse, 0);

    measure();
    measure();
    check(corr_en == 1'b1, "R8 correction enabled", corr_en, 1);
    tick();
    ov_flag = 1'b1;
    @(posedge clk); @(negedge clk);
    check(corr_en == 1'b0, "R7 withheld under ov", corr_en, 0);
    tick();
    check(soft_pulse == 1'b1, "R7 soft restart on ov", soft_pulse, 1);
    tick();
    check(soft_pulse == 1'b0, "R7 soft one tick", soft_pulse, 0);
    ov_flag = 1'b0;
    @(posedge clk); @(negedge clk);
    check(corr_en == 1'b0, "R8 still withheld after ov", corr_en, 0);
    measure();
    check(corr_en == 1'b1, "R8 restored at boundary", corr_en, 1);

    start(3'd1, 1'b0);
    tick(); tick(); tick();
    div_sel = 3'd0;
    measure();
    check(total == 13, "R9 current cycle kept", total, 13);
    measure();
    check(total == 8, "R9 new ratio next cycle", total, 8);

    uv_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    check(phase == 5'b0 && corr_en == 1'b0, "R3 idle when uv low", phase, 0);
    tick();
    check(phase == 5'b0, "R3 idle stays low", phase, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule